// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one display pipe from the pixel clock. Two counters walk each frame. The horizontal counter advances every pixel. The vertical counter advances once per line. Software sets the line length, the frame length, the sync widths, the blanking window edges and the sync polarities through a small register write port. From the counters the block drives horizontal sync, vertical sync, blank and data enable.

The sync pulses start at count 0. Blanking is defined by two edges on each axis: blanking ends after the sync pulse and the back porch, and it starts again after the active region. Active video therefore begins partway through the count range, not at count 0.

The block also provides:
- a blank-data override that replaces the incoming pixel with a programmable black colour; the override can be applied at once or held back to the next frame boundary;
- a per-frame counter and a vertical line interrupt;
- a variable frame length bounded by minimum and maximum vertical totals and ended early by an external flip event;
- readback of the current horizontal and vertical position;
- a configuration check against minimum blanking and sync widths.

Timing values are staged and take effect at the next frame start. When the generator is disabled it stops at a defined point in vertical blanking.

Top module: `raster_tgen`

## Requirements
- R1: Address 0 holds the horizontal total minus one and address 3 holds the vertical total minus one. Once bit 0 of the control word (address 8) is set, the generator starts running with both counters at 0. The horizontal count (`hpos_o`) wraps to 0 after it equals its register. The vertical count (`vpos_o`) then advances, and wraps to 0 after the line whose count equals its register.
- R2: Horizontal sync is active while the horizontal count is below the value at address 1. Vertical sync is active while the vertical count is below the value at address 4. Both are inactive while the generator is stopped.
- R3: Address 2 holds the horizontal blank end in bits [11:0] and the blank start in bits [27:16]. Address 5 holds the same two fields for the vertical axis. `blank_o` is high while the generator is stopped, or on any axis while its count is below the blank end or at or above the blank start. `de_o` is the inverse of `blank_o`.
- R4: Control bit 1 makes horizontal sync active-low and control bit 2 makes vertical sync active-low. A polarity bit of 0 gives an active-high pulse.
- R5: Address 9 holds the black colour as B in bits [9:0], G in bits [19:10] and R in bits [29:20]. While control bit 3 (blank request) is set and control bit 4 is clear, `pix_o` carries the black colour and `blank_state_o` is 1. This takes effect in the cycle after the write. Otherwise `pix_o` equals `pix_i`.
- R6: While control bit 4 (blank double-buffer) is set, the blank request in effect is the value control bit 3 had at the most recent frame wrap. A change made mid-frame has no effect on `pix_o` until the next frame starts.
- R7: `line_irq_o` is high for the single cycle in which the horizontal count is 0 and the vertical count equals the line at address 10.
- R8: When control bit 5 is set, a frame runs at least until the line held at address 6 (minimum total minus one) and at most until the line held at address 7 (maximum total minus one). Between those two lines, the frame ends after the line in which a `flip_i` pulse has been seen during that frame.
- R9: `frame_cnt_o` increments by one each time the vertical count enters the vertical blank start line.
- R10: `cfg_err_o` is high whenever the programmed values give a horizontal blank of less than 32 pixels, a vertical blank of less than 3 lines, a horizontal sync of less than 8 pixels or a vertical sync of less than 1 line. It is therefore high after reset.
- R11: When control bit 0 is cleared while running, the generator completes the line whose vertical count equals the vertical blank start. It then stops with both counts at 0 and stays stopped.
- R12: Writes to addresses 0 to 7 made while running do not change the current frame. They take effect from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register write data |
| flip_i | input | 1 | Flip event that ends a variable-length frame |
| pix_i | input | 3*COLW | Incoming pixel {R,G,B} |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Combined blanking |
| de_o | output | 1 | Data enable |
| pix_o | output | 3*COLW | Outgoing pixel, black while blank data is in effect |
| blank_state_o | output | 1 | Blank-data state currently in effect |
| line_irq_o | output | 1 | Vertical line interrupt pulse |
| cfg_err_o | output | 1 | Programmed timing violates limits |
| hpos_o | output | CW | Current horizontal count |
| vpos_o | output | CW | Current vertical count |
| frame_cnt_o | output | FCW | Frame counter |

## Verification
Register writes land on the write clock edge. Outputs decoded from the control word or from the staged registers (pixel override, blank state, configuration error) therefore change in the cycle right after the write. The counters start one edge later than the enable write, so position, sync, blank and interrupt outputs are due at a fixed offset from that start cycle: line number times line length plus pixel. Frame-boundary effects (staged timing, double-buffered blank, variable frame end, stop point) are due in the first cycle of the following frame. The bench therefore checks both the last cycle of the old frame and the first cycle of the new one. Every expected item carries the exact cycle in which it is due, and any item compared in a different cycle counts as a mismatch.

// File: rtl/raster_tgen.sv
module raster_tgen #(
  parameter int CW = 12,
  parameter int COLW = 10,
  parameter int FCW = 16,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int MIN_HBLANK = 32,
  parameter int MIN_VBLANK = 3,
  parameter int MIN_HSYNC = 8,
  parameter int MIN_VSYNC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              flip_i,
  input  logic [3*COLW-1:0] pix_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              de_o,
  output logic [3*COLW-1:0] pix_o,
  output logic              blank_state_o,
  output logic              line_irq_o,
  output logic              cfg_err_o,
  output logic [CW-1:0]     hpos_o,
  output logic [CW-1:0]     vpos_o,
  output logic [FCW-1:0]    frame_cnt_o
);
  localparam int NT = 10;
  localparam int CF = 3 * COLW;
  localparam int EW = CW + 2;
  localparam int HTOT = 0, HSW = 1, HBE = 2, HBS = 3, VTOT = 4;
  localparam int VSW = 5, VBE = 6, VBS = 7, VMIN = 8, VMAX = 9;

  logic [CW-1:0]  stg [NT];
  logic [CW-1:0]  act [NT];
  logic [5:0]     ctrl;
  logic [CF-1:0]  black;
  logic [CW-1:0]  vline;
  logic [CW-1:0]  hc, vc, vc_nxt;
  logic [FCW-1:0] fcnt;
  logic           running, flip_pend, blank_held, blank_eff;
  logic           line_end, vc_last, frame_wrap, stop_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) stg[i] <= '0;
      ctrl  <= '0;
      black <= '0;
      vline <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): stg[HTOT] <= wr_data[CW-1:0];
        AW'(1): stg[HSW]  <= wr_data[CW-1:0];
        AW'(2): begin stg[HBE] <= wr_data[CW-1:0]; stg[HBS] <= wr_data[16+:CW]; end
        AW'(3): stg[VTOT] <= wr_data[CW-1:0];
        AW'(4): stg[VSW]  <= wr_data[CW-1:0];
        AW'(5): begin stg[VBE] <= wr_data[CW-1:0]; stg[VBS] <= wr_data[16+:CW]; end
        AW'(6): stg[VMIN] <= wr_data[CW-1:0];
        AW'(7): stg[VMAX] <= wr_data[CW-1:0];
        AW'(8): ctrl  <= wr_data[5:0];
        AW'(9): black <= wr_data[CF-1:0];
        AW'(10): vline <= wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  assign line_end   = running && (hc == act[HTOT]);
  assign vc_last    = ctrl[5] ? (vc >= act[VMIN] && (flip_pend || flip_i || vc >= act[VMAX]))
                              : (vc >= act[VTOT]);
  assign frame_wrap = line_end && vc_last;
  assign stop_now   = line_end && !ctrl[0] && (vc == act[VBS]);
  assign vc_nxt     = vc_last ? '0 : vc + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; hc <= '0; vc <= '0; flip_pend <= 1'b0;
    end else if (!running) begin
      hc <= '0; vc <= '0; flip_pend <= 1'b0;
      running <= ctrl[0];
    end else if (stop_now) begin
      running <= 1'b0; hc <= '0; vc <= '0; flip_pend <= 1'b0;
    end else begin
      hc <= line_end ? '0 : hc + CW'(1);
      if (line_end) vc <= vc_nxt;
      flip_pend <= frame_wrap ? 1'b0 : (flip_pend | flip_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) act[i] <= '0;
      blank_held <= 1'b0;
      fcnt <= '0;
    end else begin
      if (!running || frame_wrap) begin
        for (int i = 0; i < NT; i++) act[i] <= stg[i];
        blank_held <= ctrl[3];
      end
      if (line_end && !stop_now && vc_nxt == act[VBS]) fcnt <= fcnt + FCW'(1);
    end
  end

  assign blank_eff     = ctrl[4] ? blank_held : ctrl[3];
  assign blank_state_o = blank_eff;
  assign pix_o         = blank_eff ? black : pix_i;

  assign hsync_o = (running && hc < act[HSW]) ^ ctrl[1];
  assign vsync_o = (running && vc < act[VSW]) ^ ctrl[2];
  assign blank_o = !running || hc < act[HBE] || hc >= act[HBS]
                            || vc < act[VBE] || vc >= act[VBS];
  assign de_o    = !blank_o;
  assign line_irq_o = running && hc == '0 && vc == vline;
  assign hpos_o = hc;
  assign vpos_o = vc;
  assign frame_cnt_o = fcnt;

  logic signed [EW-1:0] hbl, vbl;
  assign hbl = $signed({2'b00, stg[HTOT]}) + EW'(1)
             - ($signed({2'b00, stg[HBS]}) - $signed({2'b00, stg[HBE]}));
  assign vbl = $signed({2'b00, stg[VTOT]}) + EW'(1)
             - ($signed({2'b00, stg[VBS]}) - $signed({2'b00, stg[VBE]}));
  assign cfg_err_o = (hbl < $signed(EW'(MIN_HBLANK))) || (vbl < $signed(EW'(MIN_VBLANK)))
                  || (stg[HSW] < CW'(MIN_HSYNC)) || (stg[VSW] < CW'(MIN_VSYNC));

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hpos_o == act[HTOT]) |=> hpos_o == '0);
  p_hbound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> hpos_o <= act[HTOT]);
  p_idle_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !de_o);
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_irq_o && act[HTOT] != '0) |=> !line_irq_o);
  p_vrr_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && ctrl[5] && vc >= act[VMAX] && !stop_now) |=> vpos_o == '0);
  p_fcnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_cnt_o) |-> frame_cnt_o == $past(frame_cnt_o) + FCW'(1));
  p_stop_point_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(vpos_o) == $past(act[VBS]));
endmodule

// File: tb/sim_raster_tgen.sv
module sim_raster_tgen;
  localparam int CW = 12, COLW = 10, FCW = 16, AW = 4, DW = 32;
  localparam int S_HPOS = 0, S_VPOS = 1, S_HS = 2, S_VS = 3, S_DE = 4, S_BLK = 5;
  localparam int S_PIX = 6, S_BST = 7, S_IRQ = 8, S_CFG = 9, S_FCNT = 10;
  localparam int PIX_IN = 32'h0ABCDEF1;
  localparam int BLACK  = (32'h33 << 20) | (32'h22 << 10) | 32'h11;
  localparam int LIMIT  = 100000;

  logic clk = 0, rst_n = 0, wr_en = 0, flip_i = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3*COLW-1:0] pix_i = PIX_IN[3*COLW-1:0];
  logic hsync_o, vsync_o, blank_o, de_o, blank_state_o, line_irq_o, cfg_err_o;
  logic [3*COLW-1:0] pix_o;
  logic [CW-1:0] hpos_o, vpos_o;
  logic [FCW-1:0] frame_cnt_o;

  raster_tgen u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .flip_i, .pix_i,
    .hsync_o, .vsync_o, .blank_o, .de_o, .pix_o, .blank_state_o, .line_irq_o,
    .cfg_err_o, .hpos_o, .vpos_o, .frame_cnt_o);

  always #2.5 clk = ~clk;

  typedef struct { int due; int sel; int exp; string tag; } item_t;
  item_t q[$];
  item_t mon_it;
  int cyc = 0, n_chk = 0, n_bad = 0, S, F, F2, c;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int get(int sel);
    case (sel)
      S_HPOS: return int'(hpos_o);
      S_VPOS: return int'(vpos_o);
      S_HS:   return int'(hsync_o);
      S_VS:   return int'(vsync_o);
      S_DE:   return int'(de_o);
      S_BLK:  return int'(blank_o);
      S_PIX:  return int'(pix_o);
      S_BST:  return int'(blank_state_o);
      S_IRQ:  return int'(line_irq_o);
      S_CFG:  return int'(cfg_err_o);
      default: return int'(frame_cnt_o);
    endcase
  endfunction

  task automatic expect_at(int due, int sel, int exp, string tag);
    item_t it;
    int idx = q.size();
    it.due = due; it.sel = sel; it.exp = exp; it.tag = tag;
    for (int i = 0; i < q.size(); i++) if (q[i].due > due) begin idx = i; break; end
    q.insert(idx, it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      mon_it = q.pop_front();
      n_chk++;
      if (mon_it.due != cyc || get(mon_it.sel) != mon_it.exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d sel %0d: actual %0h expected %0h", mon_it.tag,
                 mon_it.due, mon_it.sel, get(mon_it.sel), mon_it.exp);
      end
    end
  end

  always @(posedge clk) if (cyc > LIMIT) begin
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic wr(int a, int d);
    wr_addr = AW'(a); wr_data = DW'(d); wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic cfg_std();
    wr(0, 63); wr(1, 8); wr(2, (44 << 16) | 12);
    wr(3, 9);  wr(4, 1); wr(5, (7 << 16) | 3);
    wr(6, 9);  wr(7, 9); wr(9, BLACK); wr(10, 5);
  endtask

  task automatic pulse_flip();
    flip_i = 1; @(posedge clk); #1; flip_i = 0;
  endtask

  initial begin
    do_reset();
    expect_at(cyc, S_BLK, 1, "R3 reset blank");
    expect_at(cyc, S_DE, 0, "R3 reset de");
    expect_at(cyc, S_HS, 0, "R2 reset hsync");
    expect_at(cyc, S_FCNT, 0, "R9 reset count");
    expect_at(cyc, S_CFG, 1, "R10 reset error");
    expect_at(cyc, S_BST, 0, "R5 reset state");
    drain();
    cfg_std();
    expect_at(cyc, S_CFG, 0, "R10 legal config");
    wr(8, 1);
    S = cyc + 1;
    expect_at(S, S_HPOS, 0, "R1 start");
    expect_at(S + 63, S_HPOS, 63, "R1 last pixel");
    expect_at(S + 64, S_HPOS, 0, "R1 hwrap");
    expect_at(S + 64, S_VPOS, 1, "R1 line step");
    expect_at(S + 639, S_VPOS, 9, "R1 last line");
    expect_at(S + 640, S_VPOS, 0, "R1 vwrap");
    expect_at(S + 7, S_HS, 1, "R2 hsync on");
    expect_at(S + 8, S_HS, 0, "R2 hsync off");
    expect_at(S + 63, S_VS, 1, "R2 vsync on");
    expect_at(S + 64, S_VS, 0, "R2 vsync off");
    expect_at(S + 192 + 11, S_DE, 0, "R3 before hblank end");
    expect_at(S + 192 + 12, S_DE, 1, "R3 at hblank end");
    expect_at(S + 192 + 43, S_DE, 1, "R3 last active");
    expect_at(S + 192 + 44, S_DE, 0, "R3 hblank start");
    expect_at(S + 384 + 20, S_DE, 1, "R3 last active line");
    expect_at(S + 448 + 20, S_BLK, 1, "R3 vblank start");
    expect_at(S + 128 + 20, S_DE, 0, "R3 vblank before end");
    expect_at(S + 447, S_FCNT, 0, "R9 before vblank");
    expect_at(S + 448, S_FCNT, 1, "R9 first vblank");
    expect_at(S + 640 + 447, S_FCNT, 1, "R9 held");
    expect_at(S + 640 + 448, S_FCNT, 2, "R9 second vblank");
    expect_at(S + 319, S_IRQ, 0, "R7 before");
    expect_at(S + 320, S_IRQ, 1, "R7 line hit");
    expect_at(S + 321, S_IRQ, 0, "R7 one cycle");
    drain();
    wr(2, (45 << 16) | 12);
    expect_at(cyc, S_CFG, 1, "R10 hblank 31");
    wr(2, (44 << 16) | 12);
    expect_at(cyc, S_CFG, 0, "R10 restored");
    wr(4, 0);
    expect_at(cyc, S_CFG, 1, "R10 vsync 0");
    wr(4, 1); wr(1, 7);
    expect_at(cyc, S_CFG, 1, "R10 hsync 7");
    drain();

    do_reset();
    cfg_std();
    wr(8, 7);
    S = cyc + 1;
    expect_at(S + 2, S_HS, 0, "R4 hsync active low");
    expect_at(S + 20, S_HS, 1, "R4 hsync idle high");
    expect_at(S + 10, S_VS, 0, "R4 vsync active low");
    expect_at(S + 70, S_VS, 1, "R4 vsync idle high");
    drain();
    wr(8, 32'hF);
    expect_at(cyc, S_PIX, BLACK, "R5 black");
    expect_at(cyc, S_BST, 1, "R5 state");
    drain();
    wr(8, 7);
    expect_at(cyc, S_PIX, PIX_IN, "R5 pass");
    drain();
    wr(8, 32'h17);
    wait_until(S + 700);
    wr(8, 32'h1F);
    c = cyc;
    expect_at(c, S_PIX, PIX_IN, "R6 deferred");
    expect_at(c, S_BST, 0, "R6 state deferred");
    expect_at(S + 1279, S_PIX, PIX_IN, "R6 frame end");
    expect_at(S + 1280, S_PIX, BLACK, "R6 applied");
    expect_at(S + 1280, S_BST, 1, "R6 state applied");
    drain();

    do_reset();
    cfg_std();
    wr(6, 7); wr(7, 11);
    wr(8, 32'h21);
    S = cyc + 1;
    expect_at(S + 767, S_VPOS, 11, "R8 max line");
    expect_at(S + 768, S_VPOS, 0, "R8 max wrap");
    F = S + 768;
    expect_at(F + 511, S_VPOS, 7, "R8 early flip held");
    expect_at(F + 512, S_VPOS, 0, "R8 ends at min");
    F2 = F + 512;
    expect_at(F2 + 639, S_VPOS, 9, "R8 flip line");
    expect_at(F2 + 640, S_VPOS, 0, "R8 ends after flip");
    wait_until(F + 130);
    pulse_flip();
    wait_until(F2 + 586);
    pulse_flip();
    drain();

    do_reset();
    cfg_std();
    wr(8, 1);
    S = cyc + 1;
    wait_until(S + 150);
    wr(0, 31);
    expect_at(S + 232, S_HPOS, 40, "R12 old length kept");
    expect_at(S + 639, S_HPOS, 63, "R12 old frame end");
    F = S + 640;
    expect_at(F + 31, S_HPOS, 31, "R12 new length");
    expect_at(F + 32, S_HPOS, 0, "R12 new wrap");
    expect_at(F + 32, S_VPOS, 1, "R12 new line");
    F2 = F + 320;
    expect_at(F2 + 255, S_VPOS, 7, "R11 runs to line end");
    expect_at(F2 + 255, S_HPOS, 31, "R11 last pixel");
    expect_at(F2 + 256, S_HPOS, 0, "R11 stopped h");
    expect_at(F2 + 256, S_VPOS, 0, "R11 stopped v");
    expect_at(F2 + 256, S_BLK, 1, "R11 blank");
    expect_at(F2 + 300, S_HPOS, 0, "R11 stays stopped");
    expect_at(F2 + 300, S_HS, 0, "R11 sync idle");
    wait_until(F2 + 69);
    wr(8, 0);
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule